// File: doc/BRIEF.md
# Boost Converter Pulse Timing Controller

This block times the gate drive of a synchronous boost converter. Each switching cycle has three parts. The boost switch conducts for a minimum on-time. A guard interval follows with both devices off. The synchronous rectifier then conducts for a minimum off-time. A second guard interval ends the cycle before the switch turns on again.

The on-time and off-time counts arrive as inputs, already scaled by the input and output voltages outside the block. The off-time count tracks the output voltage, which keeps the switching rate near 3 MHz. Three sampled comparator flags steer the timing:
- output above reference
- peak inductor current reached
- inductor current at zero

If the output is still above reference when an off-time ends, the block moves on its own into pulse-skipping operation. It holds off further pulses until the output sags, and then fires a stretched pulse. It returns to fixed-rate operation as soon as a new pulse is wanted right at the end of an off-time.

A count input of zero selects a default derived from the system clock and the nominal switching rate. An enable input turns both gate outputs off at once and clears the cycle state.

Top module: `boost_pulse_timer`

## Requirements
- R1: While `enable` is low, `swGate`, `rectGate` and `pfmActive` are low in that same cycle. All timing and mode state is cleared at the next edge. The first pulse after enable returns has the plain base on-time.
- R2: In plain operation `swGate` stays high for exactly the base on-time in clock cycles. The base on-time is `onCount`, or the default when `onCount` is zero.
- R3: When `peakLimit` is sampled high while `swGate` is high, `swGate` is low from the next cycle on.
- R4: `swGate` and `rectGate` are never high together. After either one falls, the other stays low for max(`deadCount`,1) cycles before it may rise.
- R5: `rectGate` stays high for the off-time after its guard interval. The off-time is `offCount`, or the default when `offCount` is zero. The only exceptions are the zero-current cut of R6 and a disable.
- R6: When `zeroCurrent` is sampled high while the rectifier interval runs, `rectGate` is low from the next cycle until that interval ends. The next on-time is then base + floor(base/2), saturated at 2^CNT_W-1.
- R7: `swGate` never rises after a cycle in which `fbAbove` was sampled high.
- R8: If `fbAbove` is high in the last off-time cycle, `pfmActive` goes high and no pulse starts while `fbAbove` stays high. Once it falls, a guard interval passes, then a pulse of 2*base (saturated) follows.
- R9: If `fbAbove` is low in the last off-time cycle, `pfmActive` goes low. The next pulse starts right after one guard interval with no skipped cycles, so the low time between plain pulses is 2*guard + off-time.
- R10: The default on-time is floor(P*2/5) and the default off-time is P minus that, where P = floor(CLK_HZ/SW_HZ). At 125 MHz and 3 MHz this gives 16 and 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low forces both gates off |
| fbAbove | input | 1 | Sampled flag: output above reference |
| peakLimit | input | 1 | Sampled flag: inductor peak current limit reached |
| zeroCurrent | input | 1 | Sampled flag: inductor current has reached zero |
| onCount | input | CNT_W | Base on-time in clocks (0 selects default) |
| offCount | input | CNT_W | Minimum off-time in clocks (0 selects default) |
| deadCount | input | DEAD_W | Guard interval in clocks (0 treated as 1) |
| swGate | output | 1 | Boost switch drive |
| rectGate | output | 1 | Synchronous rectifier drive |
| pfmActive | output | 1 | High while in pulse-skipping operation |

## Verification
The properties assume the inputs change only between clock edges, so `enable` cannot go low and high again within one cycle. They also assume the count inputs stay fixed while a timed interval runs. The stimulus drives every input on the falling edge. It changes `onCount`, `offCount` and `deadCount` only while `enable` is low. The comparator flags are raised at chosen points in each phase: during a pulse, during the rectifier interval, inside a guard interval and during a skip. This exercises every mode change the properties describe.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Phases of one switching cycle
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ON     = 3'd1,
    PH_DEAD_A = 3'd2,   // switch off, rectifier not yet on
    PH_OFF    = 3'd3,   // rectifier interval, minimum off-time
    PH_SKIP   = 3'd4,   // pulse-skipping hold
    PH_DEAD_B = 3'd5    // rectifier off, switch not yet on
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic loadOn;
    logic stretchPfm;
    logic stretchZc;
  } strobe_t;

  // Timer status from datapath to control
  typedef struct packed {
    logic onDone;
    logic deadDone;
    logic offDone;
  } timerFlags_t;

endpackage

// File: rtl/bpt_datapath.sv
module bpt_datapath
  import bpt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DEAD_W = 4,
  parameter int CLK_HZ = 125_000_000,
  parameter int SW_HZ  = 3_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [CNT_W-1:0]  onCount,
  input  logic [CNT_W-1:0]  offCount,
  input  logic [DEAD_W-1:0] deadCount,
  output timerFlags_t       flags
);

  localparam int PERIOD   = CLK_HZ / SW_HZ;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int ON_RAW   = (PERIOD * 2) / 5;
  localparam int ON_DEF_I = (ON_RAW < 1) ? 1 : ((ON_RAW > CNT_MAX) ? CNT_MAX : ON_RAW);
  localparam int OFF_RAW  = PERIOD - ON_DEF_I;
  localparam int OFF_DEF_I = (OFF_RAW < 1) ? 1 : ((OFF_RAW > CNT_MAX) ? CNT_MAX : OFF_RAW);
  localparam logic [CNT_W-1:0] ON_DEF  = CNT_W'(ON_DEF_I);
  localparam logic [CNT_W-1:0] OFF_DEF = CNT_W'(OFF_DEF_I);

  function automatic logic [CNT_W-1:0] satLen(input logic [CNT_W:0] v);
    return v[CNT_W] ? {CNT_W{1'b1}} : v[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  onLen;
  logic [CNT_W-1:0]  baseOn;
  logic [CNT_W-1:0]  offLen;
  logic [DEAD_W-1:0] deadLen;
  logic [CNT_W:0]    baseWide;
  logic [CNT_W:0]    cntInc;
  logic [CNT_W-1:0]  onLenNext;

  always_comb begin
    baseOn   = (onCount == '0) ? ON_DEF : onCount;
    offLen   = (offCount == '0) ? OFF_DEF : offCount;
    deadLen  = (deadCount == '0) ? DEAD_W'(1) : deadCount;
    baseWide = {1'b0, baseOn};
    if (strobe.stretchPfm)
      onLenNext = satLen(baseWide << 1);
    else if (strobe.stretchZc)
      onLenNext = satLen(baseWide + (baseWide >> 1));
    else
      onLenNext = baseOn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      onLen <= ON_DEF;
    end else begin
      if (strobe.clrCnt)
        cnt <= '0;
      else if (cnt != {CNT_W{1'b1}})
        cnt <= cnt + 1'b1;
      if (strobe.loadOn)
        onLen <= onLenNext;
    end
  end

  always_comb begin
    cntInc         = {1'b0, cnt} + 1'b1;
    flags.onDone   = cntInc >= {1'b0, onLen};
    flags.offDone  = cntInc >= {1'b0, offLen};
    flags.deadDone = cntInc >= {{(CNT_W + 1 - DEAD_W){1'b0}}, deadLen};
  end

endmodule

// File: rtl/bpt_ctrl.sv
module bpt_ctrl
  import bpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        fbAbove,
  input  logic        peakLimit,
  input  logic        zeroCurrent,
  input  timerFlags_t flags,
  output strobe_t     strobe,
  output logic        swGate,
  output logic        rectGate,
  output logic        pfmActive
);

  phase_e phase, nextPh;
  logic   pfm, nextPfm;
  logic   zcSeen, nextZc;
  logic   load;

  always_comb begin
    nextPh  = phase;
    nextPfm = pfm;
    load    = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (!fbAbove) begin
          nextPh = PH_ON;
          load   = 1'b1;
        end
      end
      PH_ON: begin
        if (peakLimit || flags.onDone) nextPh = PH_DEAD_A;
      end
      PH_DEAD_A: begin
        if (flags.deadDone) nextPh = PH_OFF;
      end
      PH_OFF: begin
        if (flags.offDone) begin
          if (fbAbove) begin
            nextPh  = PH_SKIP;
            nextPfm = 1'b1;
          end else begin
            nextPh  = PH_DEAD_B;
            nextPfm = 1'b0;
          end
        end
      end
      PH_SKIP: begin
        if (!fbAbove) nextPh = PH_DEAD_B;
      end
      PH_DEAD_B: begin
        if (flags.deadDone) begin
          if (fbAbove) begin
            nextPh  = PH_SKIP;
            nextPfm = 1'b1;
          end else begin
            nextPh = PH_ON;
            load   = 1'b1;
          end
        end
      end
      default: nextPh = PH_IDLE;
    endcase
    if (!enable) begin
      nextPh  = PH_IDLE;
      nextPfm = 1'b0;
      load    = 1'b0;
    end

    if (!enable || load)
      nextZc = 1'b0;
    else if (phase == PH_OFF && zeroCurrent)
      nextZc = 1'b1;
    else
      nextZc = zcSeen;

    strobe.clrCnt     = (nextPh != phase) || !enable;
    strobe.loadOn     = load;
    strobe.stretchPfm = pfm;
    strobe.stretchZc  = zcSeen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      pfm    <= 1'b0;
      zcSeen <= 1'b0;
    end else begin
      phase  <= nextPh;
      pfm    <= nextPfm;
      zcSeen <= nextZc;
    end
  end

  assign swGate    = enable && (phase == PH_ON);
  assign rectGate  = enable && (phase == PH_OFF) && !zcSeen;
  assign pfmActive = enable && pfm;

endmodule

// File: rtl/boost_pulse_timer.sv
module boost_pulse_timer
  import bpt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DEAD_W = 4,
  parameter int CLK_HZ = 125_000_000,
  parameter int SW_HZ  = 3_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fbAbove,
  input  logic              peakLimit,
  input  logic              zeroCurrent,
  input  logic [CNT_W-1:0]  onCount,
  input  logic [CNT_W-1:0]  offCount,
  input  logic [DEAD_W-1:0] deadCount,
  output logic              swGate,
  output logic              rectGate,
  output logic              pfmActive
);

  strobe_t     strobe;
  timerFlags_t flags;

  bpt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fbAbove    (fbAbove),
    .peakLimit  (peakLimit),
    .zeroCurrent(zeroCurrent),
    .flags      (flags),
    .strobe     (strobe),
    .swGate     (swGate),
    .rectGate   (rectGate),
    .pfmActive  (pfmActive)
  );

  bpt_datapath #(
    .CNT_W (CNT_W),
    .DEAD_W(DEAD_W),
    .CLK_HZ(CLK_HZ),
    .SW_HZ (SW_HZ)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .onCount  (onCount),
    .offCount (offCount),
    .deadCount(deadCount),
    .flags    (flags)
  );

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic fbAbove,
  input logic peakLimit,
  input logic zeroCurrent,
  input logic swGate,
  input logic rectGate,
  input logic pfmActive
);

  // R1: a low enable leaves everything idle on the following cycle
  a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!swGate && !rectGate && !pfmActive));

  // R3: the peak limit cuts the pulse
  a_r3_peak_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (swGate && peakLimit) |=> !swGate);

  // R4: never both on
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(swGate && rectGate));

  // R4: guard gap ahead of the rectifier
  a_r4_gap_before_rect: assert property (@(posedge clk) disable iff (!rst_n)
    (rectGate && !$past(rectGate)) |-> !$past(swGate));

  // R4: guard gap ahead of the switch
  a_r4_gap_before_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (swGate && !$past(swGate)) |-> !$past(rectGate));

  // R6: zero current stops the rectifier
  a_r6_zero_stops_rect: assert property (@(posedge clk) disable iff (!rst_n)
    (rectGate && zeroCurrent) |=> !rectGate);

  // R7: no turn-on decided while above reference
  a_r7_no_start_above: assert property (@(posedge clk) disable iff (!rst_n)
    (swGate && !$past(swGate)) |-> !$past(fbAbove));

  // R8: skipping stays quiet while above reference
  a_r8_pfm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pfmActive && !swGate && fbAbove) |=> !swGate);

endmodule

bind boost_pulse_timer bpt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .fbAbove    (fbAbove),
  .peakLimit  (peakLimit),
  .zeroCurrent(zeroCurrent),
  .swGate     (swGate),
  .rectGate   (rectGate),
  .pfmActive  (pfmActive)
);

// File: tb/boost_pulse_timer_tb.sv
`timescale 1ns/1ps
module boost_pulse_timer_tb;

  localparam int PER_CLK = 125_000_000 / 3_000_000;
  localparam int DEF_ON  = (PER_CLK * 2) / 5;
  localparam int DEF_OFF = PER_CLK - DEF_ON;
  localparam int LEN_MAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic fbAbove = 1'b0;
  logic peakLimit = 1'b0;
  logic zeroCurrent = 1'b0;
  logic [7:0] onCount = '0;
  logic [7:0] offCount = '0;
  logic [3:0] deadCount = '0;
  logic swGate, rectGate, pfmActive;

  always #4 clk = ~clk;

  boost_pulse_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fbAbove(fbAbove),
    .peakLimit(peakLimit), .zeroCurrent(zeroCurrent), .onCount(onCount),
    .offCount(offCount), .deadCount(deadCount), .swGate(swGate),
    .rectGate(rectGate), .pfmActive(pfmActive)
  );

  int vectors = 0;
  int fails = 0;

  // ---------------- behavioural reference ----------------
  // mPh: 0 idle, 1 pulse, 2 guard after pulse, 3 rectifier, 4 skip, 5 guard before pulse
  int mPh = 0;
  int mLeft = 0;
  bit mPfm = 0;
  bit mZc = 0;

  function automatic int guardLen();
    return (deadCount == 0) ? 1 : int'(deadCount);
  endfunction

  function automatic int offLen();
    return (offCount == 0) ? DEF_OFF : int'(offCount);
  endfunction

  function automatic int pulseLen(bit pf, bit zc);
    int b = (onCount == 0) ? DEF_ON : int'(onCount);
    int r = b;
    if (pf) r = 2 * b;
    else if (zc) r = b + b / 2;
    return (r > LEN_MAX) ? LEN_MAX : r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      mPh = 0; mLeft = 0; mPfm = 0; mZc = 0;
    end else begin
      case (mPh)
        0: if (!fbAbove) begin mLeft = pulseLen(mPfm, mZc); mZc = 0; mPh = 1; end
        1: if (peakLimit || mLeft <= 1) begin mPh = 2; mLeft = guardLen(); end
           else mLeft--;
        2: if (mLeft <= 1) begin mPh = 3; mLeft = offLen(); end
           else mLeft--;
        3: begin
             if (zeroCurrent) mZc = 1;
             if (mLeft <= 1) begin
               if (fbAbove) begin mPh = 4; mPfm = 1; end
               else begin mPh = 5; mLeft = guardLen(); mPfm = 0; end
             end else mLeft--;
           end
        4: if (!fbAbove) begin mPh = 5; mLeft = guardLen(); end
        5: if (mLeft <= 1) begin
             if (fbAbove) begin mPh = 4; mPfm = 1; end
             else begin mLeft = pulseLen(mPfm, mZc); mZc = 0; mPh = 1; end
           end else mLeft--;
        default: mPh = 0;
      endcase
    end
  end

  function automatic string phaseReq();
    case (mPh)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      5: return "R9";
      default: return "R1";
    endcase
  endfunction

  // ---------------- sampling and checks ----------------
  bit prevSw = 0, prevRect = 0, rose = 0, fell = 0, rectRose = 0, rectFell = 0;
  int runOn = 0, runOff = 0, lastOnWidth = 0, lastGap = 0;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    bit eSw, eRect, ePfm;
    @(negedge clk);
    eSw   = enable && (mPh == 1);
    eRect = enable && (mPh == 3) && !mZc;
    ePfm  = enable && mPfm;
    vectors++;
    if (swGate !== eSw) begin
      fails++; $display("FAIL %s swGate actual %0b expected %0b", phaseReq(), swGate, eSw);
    end
    if (rectGate !== eRect) begin
      fails++; $display("FAIL %s rectGate actual %0b expected %0b", phaseReq(), rectGate, eRect);
    end
    if (pfmActive !== ePfm) begin
      fails++; $display("FAIL R8 pfmActive actual %0b expected %0b", pfmActive, ePfm);
    end
    rose = 0; fell = 0; rectRose = 0; rectFell = 0;
    if (swGate) begin
      if (!prevSw) begin lastGap = runOff; rose = 1; end
      runOn++; runOff = 0;
    end else begin
      if (prevSw) begin lastOnWidth = runOn; fell = 1; end
      runOn = 0; runOff++;
    end
    if (rectGate && !prevRect) rectRose = 1;
    if (!rectGate && prevRect) rectFell = 1;
    prevSw = swGate;
    prevRect = rectGate;
  endtask

  task automatic waitRise(string req);
    for (int i = 0; i < 2000; i++) begin tick(); if (rose) return; end
    fails++; $display("FAIL %s timeout waiting for pulse start actual 0 expected 1", req);
  endtask

  task automatic waitFall(string req);
    for (int i = 0; i < 2000; i++) begin tick(); if (fell) return; end
    fails++; $display("FAIL %s timeout waiting for pulse end actual 0 expected 1", req);
  endtask

  task automatic waitRectRise(string req);
    for (int i = 0; i < 2000; i++) begin tick(); if (rectRose) return; end
    fails++; $display("FAIL %s timeout waiting for rectifier actual 0 expected 1", req);
  endtask

  task automatic waitRectFall(string req);
    for (int i = 0; i < 2000; i++) begin tick(); if (rectFell) return; end
    fails++; $display("FAIL %s timeout waiting for rectifier end actual 0 expected 1", req);
  endtask

  task automatic quietFor(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (swGate) seen++; end
    check(req, seen, 0);
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1", {swGate, rectGate, pfmActive}, 0);

    // R10: default counts, pulse and gap
    enable = 1'b1;
    waitFall("R10");
    check("R10", lastOnWidth, DEF_ON);
    waitRise("R10");
    check("R10", lastGap, 1 + DEF_OFF + 1);

    // R2, R4, R9: programmed counts
    enable = 1'b0; tick(); tick();
    onCount = 8'd8; offCount = 8'd10; deadCount = 4'd2;
    enable = 1'b1;
    waitFall("R2");
    check("R2", lastOnWidth, 8);
    waitRise("R9");
    check("R4", lastGap, 2 + 10 + 2);
    check("R9", pfmActive, 0);

    // R3: peak limit after three cycles
    tick(); tick();
    peakLimit = 1'b1;
    waitFall("R3");
    peakLimit = 1'b0;
    check("R3", lastOnWidth, 3);

    // R6: zero current in the rectifier interval
    waitRectRise("R6");
    zeroCurrent = 1'b1;
    tick();
    zeroCurrent = 1'b0;
    check("R6", rectGate, 0);
    waitFall("R6");
    check("R6", lastOnWidth, 12);
    waitFall("R6");
    check("R6", lastOnWidth, 8);

    // R8: above reference at end of off-time
    waitRectRise("R8");
    fbAbove = 1'b1;
    quietFor("R8", 30);
    check("R8", pfmActive, 1);
    fbAbove = 1'b0;
    tick(); check("R4", swGate, 0);
    tick(); check("R4", swGate, 0);
    tick(); check("R8", swGate, 1);
    waitFall("R8");
    check("R8", lastOnWidth, 16);
    waitRise("R9");
    check("R9", lastGap, 14);
    check("R9", pfmActive, 0);
    waitFall("R9");
    check("R9", lastOnWidth, 8);

    // R7: above reference raised inside the guard before a pulse
    waitRectRise("R7");
    waitRectFall("R7");
    fbAbove = 1'b1;
    quietFor("R7", 15);
    check("R7", pfmActive, 1);
    fbAbove = 1'b0;

    // R1: disable in the middle of a pulse
    waitRise("R1");
    tick();
    enable = 1'b0;
    #1;
    check("R1", {swGate, rectGate}, 0);
    tick(); tick(); tick();
    check("R1", pfmActive, 0);
    enable = 1'b1;
    waitFall("R1");
    check("R1", lastOnWidth, 8);

    // R6: stretched length saturates
    enable = 1'b0; tick();
    onCount = 8'd200;
    enable = 1'b1;
    waitRectRise("R6");
    zeroCurrent = 1'b1;
    tick();
    zeroCurrent = 1'b0;
    waitFall("R6");
    check("R6", lastOnWidth, LEN_MAX);

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule